// File: doc/BRIEF.md
# Gate Schedule Start Supervisor

This block decides when a time-aware gate schedule may start and when it has to stop. The schedule runs off a PTP clock. The block never polls. It acts only when the clock layer sends an event pulse. One pulse kind marks a clock step: a reset, a set-time or an add-time operation. The other marks a rate (frequency) trim. Each event is held in a single pending slot together with a last-operation code, and the evaluator works on them one at a time.

A rate event that arrives while the schedule is stopped makes the block do three things in order:
- write the correction period, using the longest cycle time;
- work out a start instant that is aligned to the cycle and lies safely in the future, then write it;
- issue a start command.

Later rate events compare the current PTP time with the start instant and read the engine's status bits. A clock step always issues a stop command, because the engine cannot follow a jump of the clock.

Top module: `gate_sched_supervisor`

## Requirements
- R1: After reset the block behaves as follows:
  - mode is DISABLED (code 0) and last-op is NONE (code 0);
  - every write strobe and error pulse is low;
  - the correction-period, start-time and command registers read zero.
- R2: Last-op codes are STEP=1 and RATE=2. Events are held in one pending slot, and a step always wins:
  - a step pulse sets last-op to STEP on the next cycle;
  - a rate pulse that meets a step still pending, or arrives in the same cycle as a step, leaves STEP in the slot.
- R3: A rate pulse that arrives while mode is RUNNING (code 2) is dropped. It causes no evaluation, no register write, no error pulse and no change of last-op.
- R4: The idle evaluator takes a pending event on the clock edge after the event is latched. In DISABLED:
  - a STEP causes no action;
  - a RATE writes the longest cycle time into the correction period, with its strobe raised for one cycle.
- R5: The start instant is computed as follows:
  - T = now + 1 s, in signed 64-bit nanoseconds;
  - if base >= T, the result is base − 200 ns;
  - otherwise the result is the first instant base + N·cycle that is >= T, minus 200 ns.
- R6: The start instant is written with a one-cycle strobe. The delay after the edge that takes the event is:
  - TW+1 cycles when alignment is needed (TW = time width, 64);
  - 1 cycle when base >= T.

  One cycle after that write, the command 0xC000_0000 is written (bit 31 valid, bit 30 start, bit 29 stop) and mode becomes ENABLED_NOT_RUNNING (code 1).
- R7: A STEP that is taken in mode 1 or mode 2 writes the command 0xA000_0000 (valid and stop) and sets mode to DISABLED on the same edge.
- R8: A RATE that is taken in mode 1 while now < start instant changes nothing.
- R9: A RATE that is taken in mode 1 with now >= start instant reads the status bits:
  - start=1 moves the block to mode 2;
  - otherwise stop=1 moves it to mode 0;
  - if neither bit is set, the no-status error pulses for one cycle and mode stays 1.
- R10: A RATE that is taken in mode 2 reads the status bits again:
  - start=1 keeps mode 2;
  - otherwise the unexpected-stop error pulses;
  - stop=1 then moves the block to mode 0;
  - with neither bit set, the no-status error also pulses and mode stays 2.
- R11: Every time comparison is signed, so negative base and current times align and compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step_evt_i | input | 1 | Clock-step event pulse |
| rate_evt_i | input | 1 | Rate-trim event pulse |
| now_i | input | 64 | Current PTP time, ns, signed |
| base_i | input | 64 | Earliest configured base time, ns, signed |
| cycle_i | input | 64 | Longest cycle time, ns |
| sts_start_i | input | 1 | Engine status: schedule started |
| sts_stop_i | input | 1 | Engine status: schedule stopped |
| mode_o | output | 2 | 0 DISABLED, 1 ENABLED_NOT_RUNNING, 2 RUNNING |
| last_op_o | output | 2 | 0 NONE, 1 STEP, 2 RATE |
| corr_period_o | output | 64 | Correction-period register |
| corr_we_o | output | 1 | Correction-period write strobe |
| start_time_o | output | 64 | Start-time register |
| start_we_o | output | 1 | Start-time write strobe |
| cmd_o | output | 32 | Command word |
| cmd_we_o | output | 1 | Command write strobe |
| err_no_status_o | output | 1 | Pulse: neither status bit set |
| err_stopped_o | output | 1 | Pulse: schedule stopped while RUNNING |

## Verification
The RUNNING re-check (R10) is the hardest case to reach from the ports. A rate pulse that arrives in RUNNING is dropped, and a step forces a stop, so a normal event can never trigger that evaluation. The bench reaches it by holding the rate pulse for two cycles while in mode 1 with start status set. The first copy moves the block to RUNNING. The second copy was latched while the mode was still 1, so it gets taken in RUNNING. The status bits are changed between those two edges, and this exposes both the unexpected-stop outcome and the no-status outcome.

// File: rtl/gss_pkg.sv
package gss_pkg;

    typedef enum logic [1:0] {
        MODE_DISABLED = 2'd0,
        MODE_ARMED    = 2'd1,
        MODE_RUNNING  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_STEP = 2'd1,
        OP_RATE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ALIGN = 2'd1,
        PH_ISSUE = 2'd2
    } phase_e;

    localparam int CMD_W     = 32;
    localparam int VALID_BIT = 31;
    localparam int START_BIT = 30;
    localparam int STOP_BIT  = 29;

    function automatic logic [CMD_W-1:0] make_cmd(input logic go);
        logic [CMD_W-1:0] w;
        w            = '0;
        w[VALID_BIT] = 1'b1;
        if (go) w[START_BIT] = 1'b1;
        else    w[STOP_BIT]  = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/gss_evt_latch.sv
module gss_evt_latch
    import gss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic rate_i,
    input  logic running_i,
    input  logic consume_i,
    output logic pend_o,
    output op_e  op_o
);

    typedef struct packed {
        logic pend;
        op_e  op;
    } latch_t;

    latch_t q, d;
    logic   accept;

    always_comb begin
        d      = q;
        accept = step_i || (rate_i && !running_i);
        if (accept) begin
            d.pend = 1'b1;
            if (step_i)
                d.op = OP_STEP;
            else if (q.pend && !consume_i && q.op == OP_STEP)
                d.op = OP_STEP;
            else
                d.op = OP_RATE;
        end else if (consume_i) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pend <= 1'b0;
            q.op   <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    assign pend_o = q.pend;
    assign op_o   = q.op;

    // R3: a rate pulse seen while running, with nothing pending, stays dropped
    a_r3_rate_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (running_i && rate_i && !step_i && !q.pend) |=> !q.pend);

    // R2: a step always lands as the held operation
    a_r2_step_wins: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (q.op == OP_STEP && q.pend));

endmodule

// File: rtl/gss_align.sv
module gss_align #(
    parameter int          TW         = 64,
    parameter int unsigned NS_PER_SEC = 1_000_000_000,
    parameter int unsigned DELTA_NS   = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [TW-1:0] base_i,
    input  logic [TW-1:0] cycle_i,
    input  logic [TW-1:0] now_i,
    output logic          done_o,
    output logic [TW-1:0] res_o
);

    localparam int          CW     = $clog2(TW + 1);
    localparam logic [TW-1:0] SEC_L   = TW'(NS_PER_SEC);
    localparam logic [TW-1:0] DELTA_L = TW'(DELTA_NS);
    localparam logic [CW-1:0] CNT_INIT = CW'(TW);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [TW-1:0] dvd;
        logic [TW-1:0] dvs;
        logic [TW-1:0] rem;
        logic [TW-1:0] tgt;
        logic          done;
        logic [TW-1:0] res;
    } align_t;

    align_t        q, d;
    logic [TW-1:0] tgt_c;
    logic [TW:0]   trial;
    logic [TW:0]   rem_w;
    logic [TW-1:0] pad;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        tgt_c  = now_i + SEC_L;
        trial  = {q.rem, q.dvd[TW-1]};
        rem_w  = (trial >= {1'b0, q.dvs}) ? (trial - {1'b0, q.dvs}) : trial;
        pad    = (rem_w[TW-1:0] == '0) ? '0 : (q.dvs - rem_w[TW-1:0]);
        if (go_i && !q.busy) begin
            d.tgt = tgt_c;
            if ($signed(base_i) >= $signed(tgt_c)) begin
                d.res  = base_i - DELTA_L;
                d.done = 1'b1;
            end else begin
                d.busy = 1'b1;
                d.cnt  = CNT_INIT;
                d.dvd  = tgt_c - base_i;
                d.dvs  = cycle_i;
                d.rem  = '0;
            end
        end else if (q.busy) begin
            d.rem = rem_w[TW-1:0];
            d.dvd = {q.dvd[TW-2:0], 1'b0};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.res  = q.tgt + pad - DELTA_L;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign res_o  = q.res;

    // R5: the computed instant plus one delta is never before now + 1 s
    a_r5_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($signed(q.res + DELTA_L) >= $signed(q.tgt)));

    // R5: the partial remainder always stays below the divisor
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.dvs != '0) |-> (q.rem < q.dvs));

endmodule

// File: rtl/gate_sched_supervisor.sv
module gate_sched_supervisor
    import gss_pkg::*;
#(
    parameter int          TW         = 64,
    parameter int unsigned NS_PER_SEC = 1_000_000_000,
    parameter int unsigned DELTA_NS   = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_evt_i,
    input  logic          rate_evt_i,
    input  logic [TW-1:0] now_i,
    input  logic [TW-1:0] base_i,
    input  logic [TW-1:0] cycle_i,
    input  logic          sts_start_i,
    input  logic          sts_stop_i,
    output logic [1:0]    mode_o,
    output logic [1:0]    last_op_o,
    output logic [TW-1:0] corr_period_o,
    output logic          corr_we_o,
    output logic [TW-1:0] start_time_o,
    output logic          start_we_o,
    output logic [31:0]   cmd_o,
    output logic          cmd_we_o,
    output logic          err_no_status_o,
    output logic          err_stopped_o
);

    typedef struct packed {
        phase_e           ph;
        mode_e            mode;
        logic [TW-1:0]    corr;
        logic             corr_we;
        logic [TW-1:0]    start;
        logic             start_we;
        logic [CMD_W-1:0] cmd;
        logic             cmd_we;
        logic             err_ns;
        logic             err_us;
    } sup_t;

    sup_t          q, d;
    logic          pend;
    op_e           op;
    logic          consume;
    logic          align_go;
    logic          al_done;
    logic [TW-1:0] al_res;

    gss_evt_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_evt_i),
        .rate_i    (rate_evt_i),
        .running_i (q.mode == MODE_RUNNING),
        .consume_i (consume),
        .pend_o    (pend),
        .op_o      (op)
    );

    gss_align #(
        .TW         (TW),
        .NS_PER_SEC (NS_PER_SEC),
        .DELTA_NS   (DELTA_NS)
    ) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (align_go),
        .base_i  (base_i),
        .cycle_i (cycle_i),
        .now_i   (now_i),
        .done_o  (al_done),
        .res_o   (al_res)
    );

    always_comb begin
        d          = q;
        d.corr_we  = 1'b0;
        d.start_we = 1'b0;
        d.cmd_we   = 1'b0;
        d.err_ns   = 1'b0;
        d.err_us   = 1'b0;
        consume    = 1'b0;
        align_go   = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (pend) begin
                    consume = 1'b1;
                    unique case (q.mode)
                        MODE_DISABLED: begin
                            if (op == OP_RATE) begin
                                d.corr    = cycle_i;
                                d.corr_we = 1'b1;
                                align_go  = 1'b1;
                                d.ph      = PH_ALIGN;
                            end
                        end
                        MODE_ARMED: begin
                            if (op != OP_RATE) begin
                                d.cmd    = make_cmd(1'b0);
                                d.cmd_we = 1'b1;
                                d.mode   = MODE_DISABLED;
                            end else if (!($signed(now_i) < $signed(q.start))) begin
                                if (sts_start_i)     d.mode   = MODE_RUNNING;
                                else if (sts_stop_i) d.mode   = MODE_DISABLED;
                                else                 d.err_ns = 1'b1;
                            end
                        end
                        MODE_RUNNING: begin
                            if (op != OP_RATE) begin
                                d.cmd    = make_cmd(1'b0);
                                d.cmd_we = 1'b1;
                                d.mode   = MODE_DISABLED;
                            end else if (!sts_start_i) begin
                                d.err_us = 1'b1;
                                if (sts_stop_i) d.mode   = MODE_DISABLED;
                                else            d.err_ns = 1'b1;
                            end
                        end
                        default: d.mode = MODE_DISABLED;
                    endcase
                end
            end
            PH_ALIGN: begin
                if (al_done) begin
                    d.start    = al_res;
                    d.start_we = 1'b1;
                    d.ph       = PH_ISSUE;
                end
            end
            PH_ISSUE: begin
                d.cmd    = make_cmd(1'b1);
                d.cmd_we = 1'b1;
                d.mode   = MODE_ARMED;
                d.ph     = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph       <= PH_IDLE;
            q.mode     <= MODE_DISABLED;
            q.corr     <= '0;
            q.corr_we  <= 1'b0;
            q.start    <= '0;
            q.start_we <= 1'b0;
            q.cmd      <= '0;
            q.cmd_we   <= 1'b0;
            q.err_ns   <= 1'b0;
            q.err_us   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mode_o          = q.mode;
    assign last_op_o       = op;
    assign corr_period_o   = q.corr;
    assign corr_we_o       = q.corr_we;
    assign start_time_o    = q.start;
    assign start_we_o      = q.start_we;
    assign cmd_o           = q.cmd;
    assign cmd_we_o        = q.cmd_we;
    assign err_no_status_o = q.err_ns;
    assign err_stopped_o   = q.err_us;

    // R4: register writes never overlap
    a_r4_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({corr_we_o, start_we_o, cmd_we_o}));

    // R6: arming always follows a start-time write one cycle earlier
    a_r6_arm_after_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_o == MODE_ARMED) |-> $past(start_we_o));

    // R7: a stop command leaves the block disabled
    a_r7_stop_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_o && cmd_o[STOP_BIT]) |-> (mode_o == MODE_DISABLED));

    // R9: running is only entered from the armed mode
    a_r9_run_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_o == MODE_RUNNING) |-> ($past(mode_o) == MODE_ARMED));

endmodule

// File: tb/gate_sched_supervisor_tb.sv
module gate_sched_supervisor_tb;

    localparam int TW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_evt = 1'b0, rate_evt = 1'b0;
    logic [TW-1:0] now_v = '0, base_v = '0, cycle_v = '0;
    logic          sts_start = 1'b0, sts_stop = 1'b0;
    logic [1:0]    mode_o, last_op_o;
    logic [TW-1:0] corr_o, start_o;
    logic          corr_we_o, start_we_o, cmd_we_o, err_ns_o, err_us_o;
    logic [31:0]   cmd_o;

    int    n_checks = 0, n_errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    gate_sched_supervisor #(.TW(TW)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .step_evt_i (step_evt), .rate_evt_i (rate_evt),
        .now_i (now_v), .base_i (base_v), .cycle_i (cycle_v),
        .sts_start_i (sts_start), .sts_stop_i (sts_stop),
        .mode_o (mode_o), .last_op_o (last_op_o),
        .corr_period_o (corr_o), .corr_we_o (corr_we_o),
        .start_time_o (start_o), .start_we_o (start_we_o),
        .cmd_o (cmd_o), .cmd_we_o (cmd_we_o),
        .err_no_status_o (err_ns_o), .err_stopped_o (err_us_o)
    );

    // behavioural reference model
    int          m_mode, m_op, m_ph, m_cnt;
    bit          m_pend;
    longint      m_corr, m_start, m_res;
    bit [31:0]   m_cmd;
    bit          m_corr_we, m_start_we, m_cmd_we, m_err_ns, m_err_us;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_op = 0; m_ph = 0; m_cnt = 0; m_pend = 0;
            m_corr = 0; m_start = 0; m_res = 0; m_cmd = 0;
            m_corr_we = 0; m_start_we = 0; m_cmd_we = 0; m_err_ns = 0; m_err_us = 0;
        end else begin
            bit     take, acc;
            int     old_mode, old_op;
            bit     old_pend;
            longint tgt;
            longint unsigned rr;
            old_mode = m_mode; old_op = m_op; old_pend = m_pend;
            take = (m_ph == 0) && m_pend;
            m_corr_we = 0; m_start_we = 0; m_cmd_we = 0; m_err_ns = 0; m_err_us = 0;
            if (take) begin
                if (old_mode == 0) begin
                    if (old_op == 2) begin
                        m_corr = longint'(cycle_v); m_corr_we = 1;
                        tgt = longint'(now_v) + 64'd1_000_000_000;
                        if (longint'(base_v) >= tgt) begin
                            m_res = longint'(base_v) - 200; m_cnt = 1;
                        end else begin
                            rr = longint'(tgt - longint'(base_v)) % cycle_v;
                            m_res = tgt + ((rr == 0) ? 0 : longint'(cycle_v - rr)) - 200;
                            m_cnt = TW + 1;
                        end
                        m_ph = 1;
                    end
                end else if (old_op != 2) begin
                    m_cmd = 32'hA000_0000; m_cmd_we = 1; m_mode = 0;
                end else if (old_mode == 1) begin
                    if (longint'(now_v) >= m_start) begin
                        if (sts_start)     m_mode = 2;
                        else if (sts_stop) m_mode = 0;
                        else               m_err_ns = 1;
                    end
                end else begin
                    if (!sts_start) begin
                        m_err_us = 1;
                        if (sts_stop) m_mode = 0; else m_err_ns = 1;
                    end
                end
            end else if (m_ph == 1) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_start = m_res; m_start_we = 1; m_ph = 2;
                end
            end else if (m_ph == 2) begin
                m_cmd = 32'hC000_0000; m_cmd_we = 1; m_mode = 1; m_ph = 0;
            end
            acc = step_evt || (rate_evt && old_mode != 2);
            if (acc) begin
                m_pend = 1;
                if (step_evt) m_op = 1;
                else if (old_pend && !take && old_op == 1) m_op = 1;
                else m_op = 2;
            end else if (take) m_pend = 0;
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("mode", 64'(mode_o), 64'(m_mode));
            chk("last_op", 64'(last_op_o), 64'(m_op));
            chk("corr", corr_o, m_corr);
            chk("corr_we", 64'(corr_we_o), 64'(m_corr_we));
            chk("start", start_o, m_start);
            chk("start_we", 64'(start_we_o), 64'(m_start_we));
            chk("cmd", 64'(cmd_o), 64'(m_cmd));
            chk("cmd_we", 64'(cmd_we_o), 64'(m_cmd_we));
            chk("err_no_status", 64'(err_ns_o), 64'(m_err_ns));
            chk("err_stopped", 64'(err_us_o), 64'(m_err_us));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic s, input logic r);
        @(negedge clk);
        step_evt = s; rate_evt = r;
        @(negedge clk);
        step_evt = 0; rate_evt = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        cur_req = "R1";   // reset state
        chk("R1 mode", 64'(mode_o), 0);
        chk("R1 last_op", 64'(last_op_o), 0);
        chk("R1 cmd", 64'(cmd_o), 0);
        chk("R1 start", start_o, 0);

        cur_req = "R4";   // step in DISABLED: no action
        pulse(1, 0); idle(4);
        chk("R4 no cmd", 64'(cmd_o), 0);

        cur_req = "R5";   // aligned start, long path
        base_v = 0; cycle_v = 64'd1_000_000; now_v = 64'd5_000_000_123;
        pulse(0, 1); idle(80);
        chk("R5 start", start_o, 64'd6_000_999_800);
        cur_req = "R6";
        chk("R6 armed", 64'(mode_o), 1);
        chk("R6 cmd", 64'(cmd_o), 64'h0000_0000_C000_0000);

        cur_req = "R8";   // not yet time
        now_v = 64'd6_000_000_000;
        pulse(0, 1); idle(4);

        cur_req = "R9";   // elapsed, no status bits
        now_v = 64'd6_001_000_000;
        pulse(0, 1); idle(4);
        sts_start = 1;    // elapsed, started
        pulse(0, 1); idle(4);
        chk("R9 running", 64'(mode_o), 2);

        cur_req = "R3";   // rate in RUNNING ignored
        sts_start = 0; sts_stop = 1;
        pulse(0, 1); idle(4);
        chk("R3 still running", 64'(mode_o), 2);

        cur_req = "R7";   // step in RUNNING stops
        pulse(1, 0); idle(4);
        chk("R7 stop cmd", 64'(cmd_o), 64'h0000_0000_A000_0000);
        sts_stop = 0;

        cur_req = "R6";   // base already ahead: short path
        base_v = 64'd20_000_000_000;
        pulse(0, 1); idle(8);
        cur_req = "R7";   // step in ARMED stops
        pulse(1, 0); idle(4);

        cur_req = "R11";  // negative times
        base_v = -64'sd7_000_000_000; cycle_v = 64'd300_000_007; now_v = -64'sd3_000_000_000;
        pulse(0, 1); idle(80);
        now_v = 0; sts_stop = 1;
        pulse(0, 1); idle(4);
        chk("R11 disabled", 64'(mode_o), 0);
        sts_stop = 0;

        cur_req = "R2";   // events during alignment, step priority
        base_v = 0; cycle_v = 64'd1_000_000; now_v = 64'd1_000;
        pulse(0, 1); idle(10);
        pulse(1, 0); pulse(0, 1);
        chk("R2 step held", 64'(last_op_o), 1);
        idle(80);
        pulse(1, 1); idle(4);
        chk("R2 same cycle", 64'(last_op_o), 1);

        cur_req = "R10";  // re-check in RUNNING via double rate pulse
        now_v = 64'd1_000;
        pulse(0, 1); idle(80);
        now_v = 64'd9_000_000_000; sts_start = 1;
        @(negedge clk); rate_evt = 1;
        @(negedge clk);
        @(negedge clk); rate_evt = 0; sts_start = 0; sts_stop = 0;
        idle(4);
        chk("R10 stays running", 64'(mode_o), 2);
        pulse(1, 0); idle(4);
        now_v = 64'd1_000;
        pulse(0, 1); idle(80);
        now_v = 64'd9_000_000_000; sts_start = 1;
        @(negedge clk); rate_evt = 1;
        @(negedge clk);
        @(negedge clk); rate_evt = 0; sts_start = 0; sts_stop = 1;
        idle(4);
        chk("R10 stopped", 64'(mode_o), 0);
        idle(4);
        finish_run();
    end

endmodule